// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block forms the byte a host reads back from a flash device while the device is busy with an internal program or erase. An outside controller supplies a busy level, the kind of operation, the polling-position bit of the byte being programmed, the true array data and a read strobe. The block drives the read data bus from these inputs. While the device is idle, the array data goes through unchanged. While it is busy, two status bits replace two of the data bits.

The polling bit carries the complement of the programmed byte's bit during a program operation. During an erase it is 0. This lets software see completion when the bit flips to its true value. The toggle bit starts at 0 for each new operation and inverts after every completed read until the operation ends. Software can therefore compare two consecutive reads. A new operation begins at the rising edge of the busy level. At that edge the programmed bit is captured and the toggle is cleared. Both take effect in the same cycle, through a bypass path.

Top module: `flash_status_resp`

## Requirements
- R1: While busy_i is 0, rd_data_o equals array_i on every bit.
- R2: While busy_i is 1 and op_erase_i is 0, bit 7 of rd_data_o is the complement of prog_bit_i as sampled in the first busy cycle, and it stays that way even if prog_bit_i changes later in the operation.
- R3: While busy_i is 1 and op_erase_i is 1, bit 7 of rd_data_o is 0.
- R4: While busy_i is 1, bit 6 of rd_data_o inverts once after each completed read. A read completes when rd_i falls from 1 to 0, sampled on clk. The first read of an operation returns 0.
- R5: While busy_i is 1, bits 5 to 0 of rd_data_o equal bits 5 to 0 of array_i.
- R6: A rising edge of busy_i starts a new operation. In that cycle bit 6 reads 0, whatever the toggle state was left by earlier operations.
- R7: While busy_i stays 1 and no read completes, bit 6 of rd_data_o holds its value.
- R8: While rst_n is 0, the toggle is cleared, and with busy_i at 0 rd_data_o equals array_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| prog_bit_i | input | 1 | Polling-position bit (bit 7) of the byte being programmed |
| array_i | input | 8 | True stored data at the read address |
| rd_i | input | 1 | Read strobe, high for the duration of a host read |
| rd_data_o | output | 8 | Data returned to the host |

## Verification
Several checks run on every clock. The assertions check pass-through when idle, the forced 0 during erase, and the complemented captured bit during program. They also check that the low six bits follow the array, that the toggle reads 0 at an operation start, and that it inverts after a completed read or otherwise holds. Some behaviour only the bench scenarios can show. One case is a toggle that is left at 1 by an odd number of reads and is then cleared by the next operation. Another is the hold of the captured bit after prog_bit_i changes. The bench also shows the return of true data once busy drops, and the state during reset.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } op_kind_e;

   function automatic logic poll_value(input op_kind_e kind, input logic held_bit);
      return (kind == OP_ERASE) ? 1'b0 : ~held_bit;
   endfunction

endpackage

// File: rtl/fsr_edge_detect.sv
module fsr_edge_detect #(
   parameter bit TOG_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic rd_i,
   output logic op_start_o,
   output logic rd_done_o
);

   logic busy_q;
   logic rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         busy_q <= busy_i;
         rd_q   <= rd_i;
      end
   end

   assign op_start_o = busy_i & ~busy_q;

   generate
      if (TOG_ON_FALL) begin : g_fall
         assign rd_done_o = rd_q & ~rd_i;
      end else begin : g_rise
         assign rd_done_o = ~rd_q & rd_i;
      end
   endgenerate

endmodule

// File: rtl/fsr_toggle_track.sv
module fsr_toggle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic op_start_i,
   input  logic rd_done_i,
   output logic tog_o
);

   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (op_start_i) begin
         tog_q <= 1'b0;
      end else if (busy_i && rd_done_i) begin
         tog_q <= ~tog_q;
      end
   end

   assign tog_o = op_start_i ? 1'b0 : tog_q;

endmodule

// File: rtl/fsr_poll_hold.sv
module fsr_poll_hold
   import flash_status_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     op_start_i,
   input  logic     prog_bit_i,
   input  op_kind_e kind_i,
   output logic     poll_o
);

   logic held_q;
   logic held_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
      end else if (op_start_i) begin
         held_q <= prog_bit_i;
      end
   end

   assign held_eff = op_start_i ? prog_bit_i : held_q;
   assign poll_o   = poll_value(kind_i, held_eff);

endmodule

// File: rtl/fsr_bus_mux.sv
module fsr_bus_mux #(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              busy_i,
   input  logic              poll_i,
   input  logic              tog_i,
   input  logic [DATA_W-1:0] array_i,
   output logic [DATA_W-1:0] data_o
);

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == POLL_BIT) begin : g_poll
            assign data_o[b] = busy_i ? poll_i : array_i[b];
         end else if (b == TOGGLE_BIT) begin : g_tog
            assign data_o[b] = busy_i ? tog_i : array_i[b];
         end else begin : g_pass
            assign data_o[b] = array_i[b];
         end
      end
   endgenerate

endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
   import flash_status_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int POLL_BIT    = 7,
   parameter int TOGGLE_BIT  = 6,
   parameter bit TOG_ON_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              op_erase_i,
   input  logic              prog_bit_i,
   input  logic [DATA_W-1:0] array_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int STATUS_BITS = 2;

   generate
      if (DATA_W < STATUS_BITS) begin : g_bad_width
         $error("flash_status_resp: DATA_W must be at least %0d", STATUS_BITS);
      end
      if (POLL_BIT < 0 || POLL_BIT >= DATA_W) begin : g_bad_poll
         $error("flash_status_resp: POLL_BIT out of range");
      end
      if (TOGGLE_BIT < 0 || TOGGLE_BIT >= DATA_W) begin : g_bad_tog
         $error("flash_status_resp: TOGGLE_BIT out of range");
      end
      if (POLL_BIT == TOGGLE_BIT) begin : g_bad_overlap
         $error("flash_status_resp: status bits must differ");
      end
   endgenerate

   op_kind_e kind;
   logic     op_start;
   logic     rd_done;
   logic     tog;
   logic     poll;

   assign kind = op_kind_e'(op_erase_i);

   fsr_edge_detect #(
      .TOG_ON_FALL (TOG_ON_FALL)
   ) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_i),
      .rd_i       (rd_i),
      .op_start_o (op_start),
      .rd_done_o  (rd_done)
   );

   fsr_toggle_track u_tog (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_i),
      .op_start_i (op_start),
      .rd_done_i  (rd_done),
      .tog_o      (tog)
   );

   fsr_poll_hold u_poll (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_start_i (op_start),
      .prog_bit_i (prog_bit_i),
      .kind_i     (kind),
      .poll_o     (poll)
   );

   fsr_bus_mux #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT)
   ) u_mux (
      .busy_i  (busy_i),
      .poll_i  (poll),
      .tog_i   (tog),
      .array_i (array_i),
      .data_o  (rd_data_o)
   );

endmodule

// File: rtl/flash_status_resp_chk.sv
module flash_status_resp_chk #(
   parameter int DATA_W      = 8,
   parameter int POLL_BIT    = 7,
   parameter int TOGGLE_BIT  = 6,
   parameter bit TOG_ON_FALL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_i,
   input logic              op_erase_i,
   input logic              prog_bit_i,
   input logic [DATA_W-1:0] array_i,
   input logic              rd_i,
   input logic [DATA_W-1:0] rd_data_o
);

   logic busy_prev;
   logic rd_prev;
   logic cap_bit;
   logic rd_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_prev <= 1'b0;
         rd_prev   <= 1'b0;
         cap_bit   <= 1'b0;
      end else begin
         busy_prev <= busy_i;
         rd_prev   <= rd_i;
         if (busy_i && !busy_prev) cap_bit <= prog_bit_i;
      end
   end

   assign rd_edge = TOG_ON_FALL ? (rd_prev && !rd_i) : (!rd_prev && rd_i);

   p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |-> rd_data_o == array_i);

   p_prog_poll_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !busy_prev && !op_erase_i) |-> rd_data_o[POLL_BIT] == !prog_bit_i);

   p_prog_poll_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && busy_prev && !op_erase_i) |-> rd_data_o[POLL_BIT] == !cap_bit);

   p_erase_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && op_erase_i) |-> !rd_data_o[POLL_BIT]);

   p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && busy_prev && rd_edge) |=>
         (!busy_i || rd_data_o[TOGGLE_BIT] != $past(rd_data_o[TOGGLE_BIT])));

   p_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (rd_data_o[5:0] == array_i[5:0]));

   p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !busy_prev) |-> !rd_data_o[TOGGLE_BIT]);

   p_toggle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && busy_prev && !rd_edge) |=>
         (!busy_i || $stable(rd_data_o[TOGGLE_BIT])));

endmodule

bind flash_status_resp flash_status_resp_chk #(
   .DATA_W      (DATA_W),
   .POLL_BIT    (POLL_BIT),
   .TOGGLE_BIT  (TOGGLE_BIT),
   .TOG_ON_FALL (TOG_ON_FALL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_i     (busy_i),
   .op_erase_i (op_erase_i),
   .prog_bit_i (prog_bit_i),
   .array_i    (array_i),
   .rd_i       (rd_i),
   .rd_data_o  (rd_data_o)
);

// File: tb/tb_flash_status_resp.sv
module tb_flash_status_resp;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   // {busy, erase, prog_bit, array, expected}
   localparam logic [18:0] VEC [0:NVEC-1] = '{
      {1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
      {1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C},
      {1'b1, 1'b0, 1'b1, 8'h00, 8'h00},
      {1'b1, 1'b0, 1'b0, 8'h00, 8'h80},
      {1'b1, 1'b0, 1'b0, 8'h7F, 8'hBF},
      {1'b1, 1'b1, 1'b0, 8'hFF, 8'h3F},
      {1'b1, 1'b1, 1'b1, 8'h55, 8'h15},
      {1'b1, 1'b0, 1'b1, 8'hC3, 8'h03}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       busy = 1'b0;
   logic       op_erase = 1'b0;
   logic       prog_bit = 1'b0;
   logic [7:0] array_d = 8'h00;
   logic       rd = 1'b0;
   logic [7:0] rd_data;

   int checks = 0;
   int failures = 0;
   logic exp_tog;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_status_resp dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy),
      .op_erase_i (op_erase),
      .prog_bit_i (prog_bit),
      .array_i    (array_d),
      .rd_i       (rd),
      .rd_data_o  (rd_data)
   );

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   // one complete read; samples while the strobe is high
   task automatic do_read(input string req, input logic exp_bit6);
      @(negedge clk); rd = 1'b1;
      @(negedge clk); #1;
      check1(req, rd_data[6], exp_bit6);
      rd = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R8: reset state
      array_d = 8'h99;
      #(CLK_PERIOD * 2 + 1);
      check8("R8 reset idle pass", rd_data, 8'h99);
      busy = 1'b1;
      #1;
      check1("R8 toggle clear in reset", rd_data[6], 1'b0);
      busy = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1 R2 R3 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         busy = 1'b0;
         @(negedge clk);
         {busy, op_erase, prog_bit, array_d} = VEC[i][18:8];
         #1;
         check8($sformatf("R1/R2/R3/R5 vec %0d start", i), rd_data, VEC[i][7:0]);
         @(negedge clk);
         prog_bit = ~prog_bit;
         #1;
         check8($sformatf("R2/R3 vec %0d held", i), rd_data, VEC[i][7:0]);
      end

      // R4 R7: toggle sequence during program, true bit6 = 1
      @(negedge clk); busy = 1'b0;
      @(negedge clk);
      op_erase = 1'b0; prog_bit = 1'b1; array_d = 8'h40; busy = 1'b1;
      exp_tog = 1'b0;
      for (int k = 0; k < 4; k++) begin
         do_read($sformatf("R4 read %0d", k), exp_tog);
         exp_tog = ~exp_tog;
      end
      do_read("R4 read 4", exp_tog);
      exp_tog = ~exp_tog;
      repeat (5) @(negedge clk);
      #1;
      check1("R7 hold without read", rd_data[6], exp_tog);
      check1("R2 poll during toggle test", rd_data[7], 1'b0);

      // R1: operation done, true data returns
      busy = 1'b0;
      #1;
      check8("R1 done true data", rd_data, 8'h40);

      // R6: toggle left at 1, new erase operation starts at 0
      @(negedge clk);
      op_erase = 1'b1; busy = 1'b1; array_d = 8'h7E;
      #1;
      check8("R6 new op toggle clear", rd_data, 8'h3E);
      do_read("R6 first read of new op", 1'b0);
      do_read("R4 second read of new op", 1'b1);
      busy = 1'b0; array_d = 8'hFF;
      #1;
      check8("R1 erase done reads ones", rd_data, 8'hFF);

      // R4: reads while idle leave toggle untouched for the next op
      do_read("R1 idle read true bit6", 1'b1);
      @(negedge clk);
      op_erase = 1'b0; prog_bit = 1'b0; array_d = 8'h00; busy = 1'b1;
      do_read("R4 first read after idle reads", 1'b0);

      // R8: reset mid-operation clears toggle
      do_read("R4 toggle set before reset", 1'b1);
      rst_n = 1'b0;
      #1;
      check1("R8 reset clears toggle", rd_data[6], 1'b0);
      busy = 1'b0; array_d = 8'h5A;
      #1;
      check8("R8 reset idle pass 2", rd_data, 8'h5A);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule